// File: doc/BRIEF.md
# Dual-Channel Interrupt Status and Mask Unit

This block sits on a byte-wide I/O bus inside a two-channel disk host adapter. Each channel delivers two kinds of interrupt event: one from the drive and one from the bus-master transfer engine. The block turns every event pulse into a sticky status bit. A dedicated acknowledge input clears each bit again. The block also holds a mask bit for each channel and merges the unmasked status into a single interrupt line.

Two byte locations are visible to software. The mode location has a different meaning for each direction. A write loads a mode byte with a legacy-compatibility flag and a test flag, and it is accepted only when its top bit is set. A read of the same location returns the channel-0 status. The mask location reads back a strap input that reports a legacy header, the channel-1 status and both mask bits. A write to it changes only the two mask bits.

Top module: `irq_stat_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all four status bits, both mask bits, legacy_mode, test_mode, wr_err and irq are 0.
- R2: A write to MODE_OFS with wdata[7]=1 loads legacy_mode from wdata[1] and test_mode from wdata[0]. Both outputs show the new value from the clock edge that takes the write.
- R3: A write to MODE_OFS with wdata[7]=0 leaves legacy_mode and test_mode unchanged. It raises wr_err for exactly the one cycle that follows the write edge.
- R4: While rd_en is high with addr=MODE_OFS, rdata[1] is the channel-0 bus-master status, rdata[0] is the channel-0 drive status and rdata[7:2] are 0.
- R5: While rd_en is high with addr=MASK_OFS, rdata[4]=legacy_strap, rdata[3] is the channel-1 bus-master status, rdata[2] is the channel-1 drive status, rdata[1] is the channel-1 mask, rdata[0] is the channel-0 mask, and rdata[7:5] are 0.
- R6: A write to MASK_OFS loads the channel-1 mask from wdata[1] and the channel-0 mask from wdata[0]. wdata[7:2] have no effect on any status bit or on any output.
- R7: A pulse on drv_evt[c] or bm_evt[c] sets the matching status bit at the next edge. The bit stays set until a cycle with the matching drv_clr[c] or bm_clr[c] high, and it is 0 after that edge. When set and clear arrive in the same cycle, set wins.
- R8: irq is 1 exactly when some channel c has a status bit set and its mask bit is 0.
- R9: A read at any address other than MODE_OFS and MASK_OFS returns 0. A write there changes no state. rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; rdata is valid while it is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| drv_evt | input | 2 | Drive interrupt event pulse, one bit per channel |
| bm_evt | input | 2 | Bus-master interrupt event pulse, one bit per channel |
| drv_clr | input | 2 | Acknowledge for drive status, one bit per channel |
| bm_clr | input | 2 | Acknowledge for bus-master status, one bit per channel |
| legacy_strap | input | 1 | Legacy-header strap level |
| legacy_mode | output | 1 | Legacy-compatible mode flag (0 = native) |
| test_mode | output | 1 | Test mode flag (0 = normal) |
| wr_err | output | 1 | One-cycle pulse after a rejected mode write |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with ADDR_W=4, MODE_OFS=2 and MASK_OFS=3. This leaves fourteen unmapped addresses, including 0, 1 and the top address 15, so the zero read-back and the inert writes of R9 can be checked near both mapped offsets. Every status bit is driven on its own, so the bench can show that each bit lands in its own position and can be masked. The bench also drives a set and a clear on the same bit in one cycle to check that set wins.

// File: rtl/irq_stat_pkg.sv
// Package irq_stat_pkg
// Shared constants for the interrupt status/mask unit: the channel count,
// the bus width and the bit positions software depends on.
package irq_stat_pkg;
    localparam int NCH    = 2;
    localparam int DATA_W = 8;

    // Mode byte fields (write side of the mode location)
    localparam int MODE_KEY_BIT  = 7;
    localparam int MODE_LEG_BIT  = 1;
    localparam int MODE_TEST_BIT = 0;

    // Mask location read layout
    localparam int MASK_STRAP_BIT = 4;
    localparam int MASK_C1_BM_BIT = 3;
    localparam int MASK_C1_DR_BIT = 2;

    typedef struct packed {
        logic bm;
        logic drv;
    } chan_stat_t;
endpackage

// File: rtl/irq_evt_latch.sv
// Module irq_evt_latch
// Sticky status latch for one channel: a drive bit and a bus-master bit.
// Each bit sets on its event pulse and clears on its acknowledge. Set has
// priority when both arrive in the same cycle. Assumes event and clear
// inputs are synchronous to clk.
module irq_evt_latch
    import irq_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_stat_t set_i,
    input  chan_stat_t clr_i,
    output chan_stat_t stat_o
);
    chan_stat_t stat_q;

    // Update each sticky bit: set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q.drv <= set_i.drv | (stat_q.drv & ~clr_i.drv);
            stat_q.bm  <= set_i.bm  | (stat_q.bm  & ~clr_i.bm);
        end
    end

    assign stat_o = stat_q;

    // R7: a set event is always visible at the next edge
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.drv |=> stat_o.drv);
    // R7: an acknowledged bit without a new event drops
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i.bm && !set_i.bm) |=> !stat_o.bm);
    // R7: with no event and no acknowledge, the bit holds
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i.drv && !clr_i.drv) |=> $stable(stat_o.drv));
endmodule

// File: rtl/irq_mode_reg.sv
// Module irq_mode_reg
// Write-only mode byte. It accepts a write only when the key bit is 1.
// A rejected write leaves the flags alone and pulses err_o for one cycle.
// Assumes wr_i has already been qualified by the address decode.
module irq_mode_reg
    import irq_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic key_i,
    input  logic leg_i,
    input  logic test_i,
    output logic leg_o,
    output logic test_o,
    output logic err_o
);
    logic leg_q, test_q, err_q;

    // Load the flags on a keyed write; flag an unkeyed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leg_q  <= 1'b0;
            test_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= wr_i & ~key_i;
            if (wr_i && key_i) begin
                leg_q  <= leg_i;
                test_q <= test_i;
            end
        end
    end

    assign leg_o  = leg_q;
    assign test_o = test_q;
    assign err_o  = err_q;

    // R3: an unkeyed write changes neither flag
    p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !key_i) |=> ($stable(leg_o) && $stable(test_o) && err_o));
    // R3: the error flag never lasts two cycles in a row on its own
    p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(wr_i && !key_i)) |=> !err_o);
    // R2: a keyed write lands at the next edge
    p_keyed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i) |=> (leg_o == $past(leg_i) && test_o == $past(test_i)));
endmodule

// File: rtl/irq_mask_reg.sv
// Module irq_mask_reg
// Per-channel interrupt mask bits (1 = masked). Assumes wr_i has already
// been qualified by the address decode.
module irq_mask_reg
    import irq_stat_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [NCH-1:0] mask_i,
    output logic [NCH-1:0] mask_o
);
    logic [NCH-1:0] mask_q;

    // Load the mask bits on a write, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_i)
            mask_q <= mask_i;
    end

    assign mask_o = mask_q;

    // R6: a write loads exactly the written mask at the next edge
    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(mask_i)));
    // R6: without a write the mask holds
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_stat_unit.sv
// Module irq_stat_unit
// Top of the interrupt status/mask unit. It decodes the two byte locations,
// builds the read data, holds the sticky status for each channel through
// irq_evt_latch and combines the unmasked status into irq. Assumes one
// write strobe per access; reads are combinational and have no side effects.
module irq_stat_unit
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int MODE_OFS = 2,
    parameter int MASK_OFS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NCH-1:0]    drv_evt,
    input  logic [NCH-1:0]    bm_evt,
    input  logic [NCH-1:0]    drv_clr,
    input  logic [NCH-1:0]    bm_clr,
    input  logic              legacy_strap,
    output logic              legacy_mode,
    output logic              test_mode,
    output logic              wr_err,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    chan_stat_t     stat [NCH];
    logic [NCH-1:0] mask;
    logic [NCH-1:0] chan_req;
    logic           hit_mode, hit_mask;
    logic           unused_wbits;

    assign hit_mode     = (addr == MODE_A);
    assign hit_mask     = (addr == MASK_A);
    assign unused_wbits = ^wdata[6:2];

    // One sticky latch per channel, and that channel's request term.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_stat_t set_v, clr_v;
        assign set_v.drv = drv_evt[c];
        assign set_v.bm  = bm_evt[c];
        assign clr_v.drv = drv_clr[c];
        assign clr_v.bm  = bm_clr[c];

        irq_evt_latch u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v),
            .clr_i  (clr_v),
            .stat_o (stat[c])
        );

        assign chan_req[c] = (stat[c].drv | stat[c].bm) & ~mask[c];
    end

    irq_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en & hit_mode),
        .key_i  (wdata[MODE_KEY_BIT]),
        .leg_i  (wdata[MODE_LEG_BIT]),
        .test_i (wdata[MODE_TEST_BIT]),
        .leg_o  (legacy_mode),
        .test_o (test_mode),
        .err_o  (wr_err)
    );

    irq_mask_reg u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en & hit_mask),
        .mask_i (wdata[NCH-1:0]),
        .mask_o (mask)
    );

    // Combined interrupt request.
    assign irq = |chan_req;

    // Read data: channel-0 status at the mode location, channel-1 status,
    // the strap and the masks at the mask location, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_mode) begin
                rdata[1] = stat[0].bm;
                rdata[0] = stat[0].drv;
            end else if (hit_mask) begin
                rdata[MASK_STRAP_BIT] = legacy_strap;
                rdata[MASK_C1_BM_BIT] = stat[1].bm;
                rdata[MASK_C1_DR_BIT] = stat[1].drv;
                rdata[NCH-1:0]        = mask;
            end
        end
    end

    // R8: with every channel masked no request can leave the block
    p_all_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);
    // R8: an unmasked channel-0 drive event raises irq at the next edge
    p_unmasked_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_evt[0] && !mask[0] && !(wr_en && hit_mask)) |=> irq);
    // R9: unmapped or idle reads return zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || (!hit_mode && !hit_mask)) |-> (rdata == '0));
    // R1: the first cycle after reset shows no request and no error
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !wr_err && !legacy_mode && !test_mode));
endmodule

// File: tb/test_irq_stat_unit.sv
// Directed bench for irq_stat_unit. Inputs change on the falling edge;
// outputs are sampled one step after a falling edge.
module test_irq_stat_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] drv_evt = '0, bm_evt = '0, drv_clr = '0, bm_clr = '0;
    logic       legacy_strap = 1'b0;
    logic       legacy_mode, test_mode, wr_err, irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_stat_unit #(.ADDR_W(4), .MODE_OFS(2), .MASK_OFS(3)) i_irq_stat_unit (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .drv_evt(drv_evt), .bm_evt(bm_evt),
        .drv_clr(drv_clr), .bm_clr(bm_clr), .legacy_strap(legacy_strap),
        .legacy_mode(legacy_mode), .test_mode(test_mode), .wr_err(wr_err),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [1:0] de, input logic [1:0] be,
                         input logic [1:0] dc, input logic [1:0] bc);
        @(negedge clk);
        drv_evt = de; bm_evt = be; drv_clr = dc; bm_clr = bc;
        @(negedge clk);
        drv_evt = '0; bm_evt = '0; drv_clr = '0; bm_clr = '0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 mode flags", {6'b0, legacy_mode, test_mode}, 8'h00);
        chk("R1 wr_err", {7'b0, wr_err}, 8'h00);
        bus_read(4'd2, d);
        chk("R1 ch0 status", d, 8'h00);
        bus_read(4'd3, d);
        chk("R1 masks/ch1 status", d, 8'h00);
    endtask

    task automatic t_mode();
        bus_write(4'd2, 8'h82);
        chk("R2 legacy set", {6'b0, legacy_mode, test_mode}, 8'h02);
        bus_write(4'd2, 8'h81);
        chk("R2 test set", {6'b0, legacy_mode, test_mode}, 8'h01);
        chk("R2 no error on keyed write", {7'b0, wr_err}, 8'h00);
    endtask

    task automatic t_reject();
        bus_write(4'd2, 8'h02);
        chk("R3 flags kept", {6'b0, legacy_mode, test_mode}, 8'h01);
        chk("R3 error pulse", {7'b0, wr_err}, 8'h01);
        @(negedge clk); #1;
        chk("R3 error one cycle", {7'b0, wr_err}, 8'h00);
        bus_write(4'd2, 8'h80);
        chk("R2 cleared by keyed write", {6'b0, legacy_mode, test_mode}, 8'h00);
    endtask

    task automatic t_ch0();
        logic [7:0] d;
        pulse(2'b01, 2'b00, 2'b00, 2'b00);
        bus_read(4'd2, d);
        chk("R4 ch0 drive bit0", d, 8'h01);
        chk("R8 irq from ch0 drive", {7'b0, irq}, 8'h01);
        pulse(2'b00, 2'b01, 2'b00, 2'b00);
        repeat (3) @(negedge clk);
        bus_read(4'd2, d);
        chk("R7 both ch0 bits sticky", d, 8'h03);
        pulse(2'b00, 2'b00, 2'b01, 2'b00);
        bus_read(4'd2, d);
        chk("R7 drive cleared, bm kept", d, 8'h02);
        pulse(2'b00, 2'b00, 2'b00, 2'b01);
        bus_read(4'd2, d);
        chk("R7 ch0 all cleared", d, 8'h00);
        chk("R8 irq low when idle", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_ch1();
        logic [7:0] d;
        legacy_strap = 1'b1;
        pulse(2'b10, 2'b00, 2'b00, 2'b00);
        bus_read(4'd3, d);
        chk("R5 ch1 drive bit2 and strap", d, 8'h14);
        pulse(2'b00, 2'b10, 2'b00, 2'b00);
        bus_read(4'd3, d);
        chk("R5 ch1 bm bit3", d, 8'h1C);
        bus_read(4'd2, d);
        chk("R4 ch1 not at mode location", d, 8'h00);
        pulse(2'b00, 2'b00, 2'b10, 2'b10);
        legacy_strap = 1'b0;
        bus_read(4'd3, d);
        chk("R7 ch1 cleared", d, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        bus_write(4'd3, 8'h01);
        pulse(2'b01, 2'b00, 2'b00, 2'b00);
        chk("R8 ch0 masked", {7'b0, irq}, 8'h00);
        pulse(2'b10, 2'b00, 2'b00, 2'b00);
        chk("R8 ch1 unmasked", {7'b0, irq}, 8'h01);
        bus_write(4'd3, 8'h02);
        chk("R8 ch0 now unmasked, ch1 masked", {7'b0, irq}, 8'h01);
        bus_write(4'd3, 8'h03);
        chk("R8 all masked", {7'b0, irq}, 8'h00);
        bus_read(4'd3, d);
        chk("R5 masks read back with ch1 drive", d, 8'h07);
        bus_write(4'd3, 8'hF0);
        bus_read(4'd3, d);
        chk("R6 upper bits ignored, status kept", d, 8'h04);
        bus_read(4'd2, d);
        chk("R6 ch0 status untouched", d, 8'h01);
        pulse(2'b00, 2'b00, 2'b11, 2'b00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        pulse(2'b01, 2'b00, 2'b01, 2'b00);
        bus_read(4'd2, d);
        chk("R7 set beats clear", d, 8'h01);
        pulse(2'b00, 2'b00, 2'b01, 2'b00);
        bus_read(4'd2, d);
        chk("R7 later clear works", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        pulse(2'b01, 2'b01, 2'b00, 2'b00);
        legacy_strap = 1'b1;
        bus_read(4'd0, d);
        chk("R9 addr 0 reads zero", d, 8'h00);
        bus_read(4'd1, d);
        chk("R9 addr 1 reads zero", d, 8'h00);
        bus_read(4'd15, d);
        chk("R9 addr 15 reads zero", d, 8'h00);
        bus_write(4'd1, 8'h83);
        bus_write(4'd15, 8'hFF);
        chk("R9 stray writes leave mode", {6'b0, legacy_mode, test_mode}, 8'h00);
        chk("R9 stray writes no error", {7'b0, wr_err}, 8'h00);
        bus_read(4'd3, d);
        chk("R9 stray writes leave masks", d, 8'h10);
        @(negedge clk); addr = 4'd2; #1;
        chk("R9 rdata zero without rd_en", rdata, 8'h00);
        legacy_strap = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog R1: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_mode();
        t_reject();
        t_ch0();
        t_ch1();
        t_mask();
        t_set_wins();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule